// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a free-running up-counter that wraps back to zero once it reaches a programmable modulo value. Software reaches it through a small byte-wide register port. A control/status byte sets the clock divider, the stop state, a counter-clear strobe and the interrupt enable. The same byte also holds the overflow flag. Two further bytes hold the modulo value.

The flag cannot be cleared by a single write. Software must first read the control/status byte while the flag is set, and only then write a zero to the flag. An overflow that lands between that read and that write cancels the pending clear, so an overflow event is never lost. The counter comes out of reset stopped and only starts counting after software clears the stop bit.

Top module: `modtmr_top`

## Requirements
- R1: After reset the control byte (address 0) reads 0x20, the modulo bytes read 0xFF, the count is 0, and both the flag and the interrupt request are 0.
- R2: While the stop bit (control bit 5) is 1 the count holds. While it is 0 the count rises by one per divider tick, and it resumes from the held value.
- R3: The divider select (control bits 2..0, value N) yields one tick every 2^N clocks, counted from the last counter-clear strobe.
- R4: On a tick with count equal to the modulo value, the count becomes 0 and the flag (control bit 7) becomes 1 at that same clock edge.
- R5: A read of address 0 while the flag is 1, followed by a write to address 0 with bit 7 equal to 0, clears the flag.
- R6: A write of 0 to bit 7 without a preceding arming read leaves the flag set. Any write to address 0 cancels an earlier arming read.
- R7: An overflow that occurs after the arming read and before the clearing write makes that write leave the flag at 1.
- R8: Writing 1 to bit 7 never sets the flag.
- R9: The interrupt request output is 1 exactly when the flag and the interrupt enable (control bit 6) are both 1.
- R10: Writing 1 to control bit 4 zeroes the count and the divider at that edge. Bits 4 and 3 always read as 0.
- R11: A modulo value of 0 keeps the count at 0 and sets the flag on every tick.
- R12: The modulo high byte is at address 1 and the low byte is at address 2. Both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 2 | Register address: 0 control, 1 modulo high, 2 modulo low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A corrupted arming bit shows up at the very next write of 0 to the flag. A wrongly kept arm clears a flag that should have survived an overflow. A wrongly dropped arm leaves the flag stuck. Either way the fault is visible on `ovf_flag` one edge after that write. Divider or compare faults give a wrong `count` within one tick period. A wrong wrap point misplaces the flag by a whole modulo period, and the vector table exposes this on its first run.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODH = 2'd1;
    localparam logic [ADDR_W-1:0] A_MODL = 2'd2;

    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_STOP = 5;
    localparam int B_CLR  = 4;

    typedef struct packed {
        logic             ie;
        logic             stop;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ie: 1'b0, stop: 1'b1, sel: '0};

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic flag, input ctrl_t c);
        logic [DATA_W-1:0] v;
        v         = '0;
        v[B_FLAG] = flag;
        v[B_IE]   = c.ie;
        v[B_STOP] = c.stop;
        v[SEL_W-1:0] = c.sel;
        return v;
    endfunction
endpackage

// File: rtl/modtmr_prescaler.sv
module modtmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = ~({DIV_W{1'b1}} << sel);
        tick = run && !clr && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) div_q <= '0;
        else if (run)   div_q <= div_q + 1'b1;
    end

    // R3: after a tick the selected low divider bits restart from zero
    p_tick_realign_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((div_q & $past(mask)) == '0));
endmodule

// File: rtl/modtmr_counter.sv
module modtmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = tick && (count == modulo);

    always_ff @(posedge clk) begin
        if (rst || clr)  count <= '0;
        else if (tick)   count <= wrap ? '0 : count + 1'b1;
    end

    // R2: no tick, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(count));
    // R2: a non-wrapping tick advances by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !clr) |=> count == $past(count) + 1'b1);
    // R4: a wrap lands on zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == '0);
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
    import modtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  modulo,
    output logic              flag,
    output logic              cnt_clr,
    output logic [DATA_W-1:0] rdata
);
    logic wr_ctrl, rd_ctrl, armed;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign rd_ctrl = rd_en && (addr == A_CTRL);
    assign cnt_clr = wr_ctrl && wdata[B_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RST;
            modulo <= '1;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: ctrl   <= '{ie: wdata[B_IE], stop: wdata[B_STOP], sel: wdata[SEL_W-1:0]};
                A_MODH: modulo[CNT_W-1:DATA_W] <= wdata;
                A_MODL: modulo[DATA_W-1:0]     <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  armed <= 1'b0;
        else if (wrap || wr_ctrl) armed <= 1'b0;
        else if (rd_ctrl && flag) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                                       flag <= 1'b0;
        else if (wrap)                                 flag <= 1'b1;
        else if (wr_ctrl && !wdata[B_FLAG] && armed)   flag <= 1'b0;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = pack_ctrl(flag, ctrl);
            A_MODH:  rdata = modulo[CNT_W-1:DATA_W];
            A_MODL:  rdata = modulo[DATA_W-1:0];
            default: rdata = '0;
        endcase
    end

    // R4: every wrap leaves the flag set
    p_flag_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);
    // R8: the flag only rises through a wrap
    p_no_spont_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag && !wrap) |=> !flag);
    // R6: without an arming read the flag cannot drop
    p_clear_needs_arm_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !armed) |=> flag);
    // R7: a fresh overflow cancels a pending clear
    p_wrap_disarms_r7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !armed);
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import modtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] modulo;
    logic             cnt_clr, tick, wrap;

    modtmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wrap(wrap), .ctrl(ctrl), .modulo(modulo),
        .flag(ovf_flag), .cnt_clr(cnt_clr), .rdata(rdata)
    );

    modtmr_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst(rst), .run(!ctrl.stop), .clr(cnt_clr),
        .sel(ctrl.sel), .tick(tick)
    );

    modtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .clr(cnt_clr),
        .modulo(modulo), .count(count), .wrap(wrap)
    );

    assign irq = ovf_flag && ctrl.ie;

    // R2: a stopped timer produces no ticks
    p_stop_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.stop |-> !tick);
endmodule

// File: tb/modtmr_top_bench.sv
module modtmr_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [1:0]  addr;
    logic [7:0]  wdata, rdata;
    logic [15:0] count;
    logic        ovf_flag, irq;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    modtmr_top u_modtmr_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .count(count), .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] modv;
        logic [15:0] cyc;
        logic [15:0] exp;
    } vec_t;

    // expected count = (cyc >> sel) mod (modv + 1)
    localparam vec_t VEC [7] = '{
        '{3'd0, 16'hFFFF, 16'd10,  16'd10},
        '{3'd1, 16'hFFFF, 16'd10,  16'd5},
        '{3'd3, 16'hFFFF, 16'd20,  16'd2},
        '{3'd7, 16'hFFFF, 16'd300, 16'd2},
        '{3'd0, 16'h0004, 16'd7,   16'd2},
        '{3'd2, 16'h0002, 16'd25,  16'd0},
        '{3'd0, 16'h0000, 16'd5,   16'd0}
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // tasks start at a negedge and return at the next negedge (one clock edge)
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1ms;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(2'd0, d); check(16'(d), 16'h20, "R1 ctrl");
        rd(2'd1, d); check(16'(d), 16'hFF, "R1 modh");
        rd(2'd2, d); check(16'(d), 16'hFF, "R1 modl");
        check(count, 16'h0, "R1 count");
        check(16'({ovf_flag, irq}), 16'h0, "R1 flag/irq");
        idle(4);
        check(count, 16'h0, "R2 stopped after reset");

        // R12 modulo byte placement
        wr(2'd1, 8'h12); wr(2'd2, 8'h34);
        rd(2'd1, d); check(16'(d), 16'h12, "R12 high byte");
        rd(2'd2, d); check(16'(d), 16'h34, "R12 low byte");

        // table: R3 divider, R4 wrap, R11 zero modulo
        foreach (VEC[i]) begin
            wr(2'd0, 8'h20);
            wr(2'd1, VEC[i].modv[15:8]);
            wr(2'd2, VEC[i].modv[7:0]);
            wr(2'd0, 8'h10 | 8'(VEC[i].sel));
            idle(int'(VEC[i].cyc));
            check(count, VEC[i].exp, $sformatf("R3/R4 vector %0d", i));
            if (VEC[i].modv == 16'h0) check(16'(ovf_flag), 16'h1, "R11 flag on zero modulo");
        end

        // R2 stop and resume
        wr(2'd0, 8'h20); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
        wr(2'd0, 8'h10);
        idle(5);
        check(count, 16'd5, "R2 running");
        wr(2'd0, 8'h20);
        check(count, 16'd6, "R2 stop edge");
        idle(10);
        check(count, 16'd6, "R2 held while stopped");
        wr(2'd0, 8'h00);
        idle(3);
        check(count, 16'd9, "R2 resumes from held value");

        // R10 clear strobe and read-as-zero bits
        wr(2'd0, 8'h38);
        check(count, 16'd0, "R10 strobe zeroes count");
        rd(2'd0, d); check(16'(d & 8'h18), 16'h0, "R10 bits 4,3 read 0");

        // flag clear sequence: modulo 3, divide by 1
        wr(2'd0, 8'h20); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
        wr(2'd0, 8'h10);
        idle(4);
        check(16'(ovf_flag), 16'h1, "R4 flag set at wrap");
        check(count, 16'd0, "R4 count wraps to 0");
        wr(2'd0, 8'h20);
        check(16'(ovf_flag), 16'h1, "R6 zero write without read");
        wr(2'd0, 8'h20);
        check(16'(ovf_flag), 16'h1, "R6 zero write again");
        rd(2'd0, d); check(16'(d), 16'hA0, "R5 read shows flag");
        wr(2'd0, 8'h60);
        check(16'(ovf_flag), 16'h0, "R5 cleared after read");
        check(16'(irq), 16'h0, "R9 no irq with flag 0");
        wr(2'd0, 8'hE0);
        check(16'(ovf_flag), 16'h0, "R8 writing 1 has no effect");

        // R6 disarm by intervening write: get flag (timer stopped afterwards)
        wr(2'd0, 8'h10);
        idle(4);
        wr(2'd0, 8'h20);
        rd(2'd0, d);
        wr(2'd0, 8'hA0);
        wr(2'd0, 8'h20);
        check(16'(ovf_flag), 16'h1, "R6 write cancels arm");

        // R7: modulo 0, divide by 8 -> wrap on edges 8, 16, 24 after strobe
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        rd(2'd0, d); wr(2'd0, 8'h20);
        check(16'(ovf_flag), 16'h0, "R5 clear while stopped");
        wr(2'd0, 8'h13);            // edge 0
        idle(8);                    // edges 1..8
        check(16'(ovf_flag), 16'h1, "R11 flag per tick");
        rd(2'd0, d);                // edge 9 arms
        wr(2'd0, 8'h03);            // edge 10 clears
        check(16'(ovf_flag), 16'h0, "R5 clear while running");
        idle(6);                    // edges 11..16
        rd(2'd0, d);                // edge 17 arms
        idle(7);                    // edges 18..24, wrap at 24
        wr(2'd0, 8'h43);            // edge 25
        check(16'(ovf_flag), 16'h1, "R7 overflow cancels clear");
        check(16'(irq), 16'h1, "R9 irq with flag and enable");
        wr(2'd0, 8'h23);
        check(16'(irq), 16'h0, "R9 irq off with enable 0");

        finish_run();
    end
endmodule